// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Emulator

This block stands in for a 64K x 1 dynamic memory when a memory controller is tested. It takes active-low row strobe, column strobe and write-enable pins, a narrow shared address bus and a one-bit data input. It returns one data bit together with an enable that stands in for a three-state output. All pins are sampled on the system clock. Every strobe edge is found by comparing the current sample with the one from the previous clock.

The address arrives in two halves. The row half is taken on the row strobe falling edge and the column half on the column strobe falling edge. Keeping the row strobe low across several column pulses gives page-mode access to one row. Each row-strobe falling edge also refreshes one refresh row. The emulator keeps a clock-cycle age counter for every refresh row and raises a sticky violation flag when a row goes unrefreshed past the deadline. The flag records which row failed first.

`ADDR_W` sets the address pin count, so the array holds 2^(2*ADDR_W) bits. The full-size part uses `ADDR_W = 8`. The default of 6 keeps elaboration light. `REFRESH_LIMIT` is the deadline in clock cycles. Its default of 200000 is 2 ms at 100 MHz.

Top module: `dram_emu`

## Requirements
- R1: After reset, every cell reads 0, `oe_o` is 0, `refresh_viol_o` is 0 and `viol_row_o` is 0.
- R2: The row is taken from `addr_i` in the cycle where `ras_n_i` is first sampled low. Changing `addr_i` while `ras_n_i` stays low does not change the row used by later column accesses.
- R3: A column-strobe falling edge has no effect while `ras_n_i` is high. It does not enable the output and it writes nothing.
- R4: On the clock edge that first samples `cas_n_i` low (with `ras_n_i` low), `oe_o` goes to 1 and `dout_o` shows the cell at {row, `addr_i`}, with the row in the upper bits. Both hold while `cas_n_i` stays low. `oe_o` returns to 0 after the first edge that samples `cas_n_i` high.
- R5: Early write: if `we_n_i` is low on the edge that first samples `cas_n_i` low, the value of `din_i` at that edge is stored. `oe_o` still goes to 1 during the write, and `dout_o` is then undefined.
- R6: Late write: if `we_n_i` falls while an accepted column access is still held low, the value of `din_i` on that edge is stored at the latched row and column.
- R7: Page mode: while `ras_n_i` stays low, each new column-strobe pulse reads or writes a new column in the latched row.
- R8: Every row-strobe falling edge restarts the age of refresh row `addr_i[ADDR_W-2:0]`. The top address bit is ignored for refresh.
- R9: `refresh_viol_o` goes to 1 on the edge `REFRESH_LIMIT`+1 cycles after the last refresh edge of a row. It then stays set until reset. `viol_row_o` keeps the first expiring row, and the lowest index wins when several rows expire together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock on which all pins are sampled |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Shared row/column address pins |
| din_i | input | 1 | Write data |
| dout_o | output | 1 | Read data |
| oe_o | output | 1 | Output enable (1 = driving, 0 = high impedance) |
| refresh_viol_o | output | 1 | Sticky refresh deadline violation |
| viol_row_o | output | ADDR_W-1 | Index of the first refresh row that expired |

## Verification
A bad latched row or column shows up on `dout_o` as soon as a later read touches the affected cell, one cycle after its column strobe. The bench therefore reads back every pattern it writes, in normal, late and page cycles. A wrong output-enable state shows at the first edge after the column strobe moves. A wrong refresh age shows only when the deadline is reached. To catch it, the bench checks the exact cycle the flag rises, measured from a refresh that uses the top address bit, and it checks which row the flag names.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  typedef struct packed {
    logic row_strobe;  // row strobe falling edge
    logic col_strobe;  // column strobe falling edge, gated by row strobe
    logic late_wr;     // write-enable fall inside an accepted column access
    logic col_active;  // column access held since its strobe
  } strobe_ev_t;
endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ras_n_i,
  input  logic                     cas_n_i,
  input  logic                     we_n_i,
  output dram_emu_pkg::strobe_ev_t ev_o
);
  logic ras_q, cas_q, we_q, act_q;
  logic row_fall, col_fall, wr_late;

  assign row_fall = ras_q & ~ras_n_i;
  assign col_fall = cas_q & ~cas_n_i & ~ras_n_i;
  assign wr_late  = we_q & ~we_n_i & act_q & ~cas_n_i & ~ras_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
      act_q <= 1'b0;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
      we_q  <= we_n_i;
      if (cas_n_i)       act_q <= 1'b0;
      else if (col_fall) act_q <= 1'b1;
    end
  end

  always_comb begin
    ev_o.row_strobe = row_fall;
    ev_o.col_strobe = col_fall;
    ev_o.late_wr    = wr_late;
    ev_o.col_active = act_q;
  end

  // R3
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(!ras_n_i && !cas_n_i));
  // R4
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cas_n_i) |-> !act_q);
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ADDR_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  dram_emu_pkg::strobe_ev_t ev_i,
  input  logic                     we_n_i,
  input  logic                     ras_n_i,
  input  logic                     cas_n_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     din_i,
  output logic                     dout_o
);
  localparam int IDX_W = 2 * ADDR_W;
  localparam int CELLS = 1 << IDX_W;

  logic [ADDR_W-1:0] row_q, col_q;
  logic [CELLS-1:0]  mem_q;
  logic              dout_q;
  logic [IDX_W-1:0]  cas_idx, wr_idx;
  logic              wr_en;

  assign cas_idx = {row_q, addr_i};
  assign wr_en   = (ev_i.col_strobe & ~we_n_i) | ev_i.late_wr;
  assign wr_idx  = ev_i.col_strobe ? cas_idx : {row_q, col_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      mem_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      if (ev_i.row_strobe) row_q <= addr_i;
      if (ev_i.col_strobe) begin
        col_q  <= addr_i;
        dout_q <= mem_q[cas_idx];
      end
      if (wr_en) mem_q[wr_idx] <= din_i;
    end
  end

  assign dout_o = dout_q;

  // R2
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_q) |-> $past(!ras_n_i));
  // R5
  mem_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_q) |-> $past(!ras_n_i && !cas_n_i && !we_n_i));
endmodule

// File: rtl/dram_refresh_monitor.sv
module dram_refresh_monitor #(
  parameter int ROW_BITS = 5,
  parameter int LIMIT    = 200000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [ROW_BITS-1:0] idx_i,
  output logic                viol_o,
  output logic [ROW_BITS-1:0] viol_row_o
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int AGE_W = $clog2(LIMIT + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(LIMIT);

  logic [ROWS-1:0]     expired;
  logic [ROW_BITS-1:0] first_idx;
  logic                viol_q;
  logic [ROW_BITS-1:0] row_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   age_q <= '0;
      else if (strobe_i && idx_i == ROW_BITS'(r))    age_q <= '0;
      else if (age_q != AGE_MAX)                     age_q <= age_q + 1'b1;
    end
    assign expired[r] = (age_q == AGE_MAX);
  end

  // lowest expired index wins
  always_comb begin
    first_idx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (expired[r]) first_idx = ROW_BITS'(r);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      row_q  <= '0;
    end else if (!viol_q && |expired) begin
      viol_q <= 1'b1;
      row_q  <= first_idx;
    end
  end

  assign viol_o     = viol_q;
  assign viol_row_o = row_q;

  // R9
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(viol_q) |-> (viol_q && $stable(row_q)));
endmodule

// File: rtl/dram_emu.sv
module dram_emu #(
  parameter int ADDR_W        = 6,
  parameter int REFRESH_LIMIT = 200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              oe_o,
  output logic              refresh_viol_o,
  output logic [ADDR_W-2:0] viol_row_o
);
  localparam int ROW_BITS = ADDR_W - 1;

  dram_emu_pkg::strobe_ev_t ev;

  dram_strobe_decode u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .ev_o    (ev)
  );

  dram_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .we_n_i  (we_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .dout_o  (dout_o)
  );

  dram_refresh_monitor #(.ROW_BITS(ROW_BITS), .LIMIT(REFRESH_LIMIT)) u_refresh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (ev.row_strobe),
    .idx_i      (addr_i[ROW_BITS-1:0]),
    .viol_o     (refresh_viol_o),
    .viol_row_o (viol_row_o)
  );

  assign oe_o = ev.col_active;
endmodule

// File: tb/dram_emu_tb.sv
module dram_emu_tb_top;
  localparam int AW    = 6;
  localparam int LIMIT = 300;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, oe, viol;
  logic [AW-2:0] viol_row;

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;
  int t_seen   = -1;
  bit mon_en   = 1'b0;
  bit model [0:4095];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_emu #(.ADDR_W(AW), .REFRESH_LIMIT(LIMIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .addr_i(addr), .din_i(din), .dout_o(dout), .oe_o(oe),
    .refresh_viol_o(viol), .viol_row_o(viol_row)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // set pins, let one edge sample them, return at the following negedge
  task automatic drive(input logic r, input logic c, input logic w,
                       input logic [AW-1:0] a, input logic d);
    ras_n = r; cas_n = c; we_n = w; addr = a; din = d;
    @(negedge clk);
    if (mon_en && viol && t_seen < 0) t_seen = cyc;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0; din = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    foreach (model[i]) model[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic ras_only(input logic [AW-1:0] r);
    drive(0, 1, 1, r, 0);
    drive(1, 1, 1, r, 0);
  endtask

  task automatic sweep();
    for (int i = 0; i < 32; i++) ras_only(AW'(i));
  endtask

  task automatic write_early(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic d);
    drive(0, 1, 1, r, 0);
    drive(0, 0, 0, c, d);
    chk("R5 oe in write", oe, 1);
    drive(1, 1, 1, 0, 0);
    model[{r, c}] = d;
  endtask

  task automatic write_late(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic d);
    drive(0, 1, 1, r, 0);
    drive(0, 0, 1, c, ~d);
    drive(0, 0, 0, c, d);
    drive(1, 1, 1, 0, 0);
    model[{r, c}] = d;
  endtask

  task automatic read_chk(input logic [AW-1:0] r, input logic [AW-1:0] c, input string req);
    drive(0, 1, 1, r, 0);
    drive(0, 0, 1, c, 0);
    chk({req, " oe"}, oe, 1);
    chk({req, " data"}, dout, model[{r, c}]);
    drive(0, 0, 1, ~c, 0);
    chk("R4 held data", dout, model[{r, c}]);
    chk("R4 held oe", oe, 1);
    drive(1, 1, 1, 0, 0);
    chk("R4 oe off", oe, 0);
  endtask

  task automatic t_reset();
    chk("R1 oe", oe, 0);
    chk("R1 viol", viol, 0);
    chk("R1 viol row", viol_row, 0);
    read_chk(0, 0, "R1 cell");
    read_chk(63, 63, "R1 cell");
  endtask

  task automatic t_early();
    sweep();
    write_early(3, 10, 1);
    write_early(3, 11, 0);
    write_early(40, 10, 1);
    write_early(63, 63, 1);
    read_chk(3, 10, "R5");
    read_chk(3, 11, "R5");
    read_chk(40, 10, "R5");
    read_chk(8, 10, "R5 alias");
    read_chk(63, 63, "R5");
    chk("R9 no false flag", viol, 0);
  endtask

  task automatic t_late();
    sweep();
    write_late(5, 20, 1);
    read_chk(5, 20, "R6");
    write_late(63, 63, 0);
    read_chk(63, 63, "R6 overwrite");
    write_late(17, 1, 1);
    read_chk(17, 1, "R6");
  endtask

  task automatic t_row_hold();
    sweep();
    drive(0, 1, 1, 20, 0);
    drive(0, 1, 1, 33, 0);
    drive(0, 0, 0, 4, 1);
    drive(1, 1, 1, 0, 0);
    model[{6'd20, 6'd4}] = 1'b1;
    read_chk(20, 4, "R2 latched row");
    read_chk(33, 4, "R2 other row");
  endtask

  task automatic t_page();
    sweep();
    drive(0, 1, 1, 12, 0);
    for (int c = 0; c < 8; c++) begin
      drive(0, 0, 0, AW'(c + 30), logic'((c * 5) % 3 == 1));
      drive(0, 1, 1, AW'(c + 30), 0);
      model[{6'd12, 6'(c + 30)}] = logic'((c * 5) % 3 == 1);
    end
    for (int c = 0; c < 8; c++) begin
      drive(0, 0, 1, AW'(c + 30), 0);
      chk("R7 page oe", oe, 1);
      chk("R7 page data", dout, model[{6'd12, 6'(c + 30)}]);
      drive(0, 1, 1, AW'(c + 30), 0);
      chk("R7 oe between", oe, 0);
    end
    drive(1, 1, 1, 0, 0);
    read_chk(12, 31, "R7 normal read");
    read_chk(12, 32, "R7 normal read");
  endtask

  task automatic t_gated();
    sweep();
    write_early(9, 9, 1);
    drive(1, 1, 1, 9, 0);
    drive(1, 0, 0, 9, 0);
    chk("R3 no oe", oe, 0);
    drive(1, 0, 0, 9, 0);
    chk("R3 no oe held", oe, 0);
    drive(1, 1, 1, 9, 0);
    read_chk(9, 9, "R3 no write");
  endtask

  task automatic t_refresh();
    int t_ref = 0;
    sweep();
    t_seen = -1;
    mon_en = 1'b1;
    for (int rd = 0; rd < 8; rd++) begin
      for (int r = 0; r < 32; r++) begin
        if (r == 7) continue;
        if (rd == 1 && r == 16) begin
          drive(0, 1, 1, 39, 0);  // refresh row 7 via top address bit
          t_ref = cyc;
          drive(1, 1, 1, 0, 0);
        end
        ras_only(AW'(r));
      end
    end
    chk("R8 refresh alias timing", t_seen - t_ref, LIMIT + 1);
    chk("R9 flag", viol, 1);
    chk("R9 first row", viol_row, 7);
    mon_en = 1'b0;
    repeat (LIMIT + 20) @(negedge clk);
    chk("R9 sticky flag", viol, 1);
    chk("R9 sticky row", viol_row, 7);
  endtask

  task automatic t_reset_clears();
    write_early(2, 2, 1);
    read_chk(2, 2, "R5 pre-reset");
    do_reset();
    chk("R1 viol cleared", viol, 0);
    read_chk(2, 2, "R1 cell cleared");
  endtask

  task automatic t_tie();
    do_reset();
    ras_only(0);
    ras_only(1);
    ras_only(2);
    repeat (LIMIT + 10) @(negedge clk);
    chk("R9 tie flag", viol, 1);
    chk("R9 tie lowest", viol_row, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_early();
    t_late();
    t_row_hold();
    t_page();
    t_gated();
    t_refresh();
    t_reset_clears();
    t_tie();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule